// File: doc/BRIEF.md
# Error Code Interrupt Aggregator

This block gathers 3-bit error codes from thirteen reporting agents (storage partitions, a direct-access unit and a life-cycle interface). Each agent owns a read-only code register, and that register always shows the last code the agent reported. A status word carries one bit per agent. The bit is set while that agent's code is nonzero. A code that software can recover from returns to zero when the agent begins a new command. Codes that are not recoverable stay in place.

Any nonzero report sets a sticky error interrupt. Reports that indicate macro or check failures also emit single-cycle fatal alert events. A second sticky interrupt records operation completion. Each interrupt has an enable bit and a software force bit, and a separate alert-test register fires individual alert events. Software reaches all registers through a plain valid/write/address/data port. Read data returns one cycle after the request.

Top module: `err_irq_agg`

## Requirements
- R1: The 3-bit code register of agent i is read at address 0x40+4*i, in bits 2:0. A report from agent i captures its code. The encoding is 0 none, 1 macro, 2 correctable ECC, 3 uncorrectable ECC, 4 write-blank, 5 access, 6 check-fail, 7 FSM state.
- R2: The status word at address 0x00 holds a 1 in bit i, for i in 0 to 12, exactly when agent i's code register is nonzero.
- R3: When an agent signals a command start while its code is 2, 4 or 5, the code becomes 0. A command start leaves codes 1, 3, 6 and 7 unchanged. A report in the same cycle as a command start takes priority.
- R4: Any report with a nonzero code sets bit 1 of the interrupt state register, and the bit stays set. A report of code 0 does not set it.
- R5: Reports of code 1 or 3 pulse `alert_macro` for one cycle. Reports of code 6 or 7 pulse `alert_check` for one cycle. The pulse appears in the cycle after the report. Other codes fire neither alert.
- R6: The interrupt state register is at 0x04. Bit 1 is error and bit 0 is operation-done, and both are write-1-to-clear. A pulse on `op_done` sets bit 0.
- R7: When hardware sets a state bit in the same cycle that software writes 1 to clear it, the bit ends set.
- R8: The enable register at 0x08 can be read and written, with the same bit layout. Each interrupt output equals the AND of its state bit and its enable bit, registered one cycle later.
- R9: Writing 1 to a bit of the test register at 0x0C forces the matching state bit to 1. The test register reads as 0.
- R10: Writing to the alert-test register at 0x10 fires one single-cycle event for each bit written as 1. Bit 0 is macro, bit 1 is check, bit 2 is bus integrity, bit 3 is primitive fatal and bit 4 is primitive recoverable.
- R11: After reset, all code registers, the status word, the state register, the enable register, the interrupt outputs and the alert outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| agent_err_valid | input | 13 | Per-agent error report strobe |
| agent_err_code | input | 39 | Packed 3-bit codes, agent i in bits 3i+2:3i |
| agent_cmd_start | input | 13 | Per-agent new command start strobe |
| op_done | input | 1 | Operation completion pulse |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_error | output | 1 | Error interrupt line |
| irq_op_done | output | 1 | Operation-done interrupt line |
| alert_macro | output | 1 | Fatal macro alert event |
| alert_check | output | 1 | Fatal check alert event |
| alert_bus_integ | output | 1 | Bus integrity alert event (test only) |
| alert_prim_fatal | output | 1 | Primitive fatal alert event (test only) |
| alert_prim_recov | output | 1 | Primitive recoverable alert event (test only) |

## Verification
The classifier is driven with codes from every class: the recoverable codes 2, 4 and 5, the macro class 1 and 3, the check class 7, and the neutral code 0. Each of these distinguishes the alert routing and the interrupt setting. Command starts go to agents holding recoverable codes and to agents holding fatal codes, which separates clearing from retention. One case puts a command start and a report in the same cycle. Collisions between a hardware set and a software clear on both state bits check the priority. The enable and test paths check the output gating and the force-to-one behaviour.

// File: rtl/err_irq_agg_pkg.sv
package err_irq_agg_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE    = 3'd0,
    EC_MACRO   = 3'd1,
    EC_ECC_FIX = 3'd2,
    EC_ECC_BAD = 3'd3,
    EC_BLANK   = 3'd4,
    EC_LOCKED  = 3'd5,
    EC_CHECK   = 3'd6,
    EC_STATE   = 3'd7
  } err_code_e;

  localparam int NUM_IRQ      = 2;
  localparam int IRQ_DONE_BIT = 0;
  localparam int IRQ_ERR_BIT  = 1;

  localparam int NUM_ALERTS       = 5;
  localparam int ALT_MACRO        = 0;
  localparam int ALT_CHECK        = 1;
  localparam int ALT_BUS          = 2;
  localparam int ALT_PRIM_FATAL   = 3;
  localparam int ALT_PRIM_RECOV   = 4;

  function automatic logic code_recoverable(input logic [CODE_W-1:0] c);
    return (c == EC_ECC_FIX) || (c == EC_BLANK) || (c == EC_LOCKED);
  endfunction

  function automatic logic code_macro_fatal(input logic [CODE_W-1:0] c);
    return (c == EC_MACRO) || (c == EC_ECC_BAD);
  endfunction

  function automatic logic code_check_fatal(input logic [CODE_W-1:0] c);
    return (c == EC_CHECK) || (c == EC_STATE);
  endfunction
endpackage

// File: rtl/agent_code_slot.sv
module agent_code_slot
  import err_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rep_valid,
  input  logic [CODE_W-1:0] rep_code,
  input  logic              cmd_start,
  output logic [CODE_W-1:0] code_q,
  output logic              err_hit,
  output logic              macro_hit,
  output logic              check_hit
);
  logic drop_recov;
  assign drop_recov = cmd_start && code_recoverable(code_q);

  always_ff @(posedge clk) begin
    if (rst)             code_q <= '0;
    else if (rep_valid)  code_q <= rep_code;
    else if (drop_recov) code_q <= '0;
  end

  assign err_hit   = rep_valid && (rep_code != '0);
  assign macro_hit = rep_valid && code_macro_fatal(rep_code);
  assign check_hit = rep_valid && code_check_fatal(rep_code);

  AST_CODE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> code_q == $past(rep_code)); // R1
  AST_RECOV_DROP: assert property (@(posedge clk) disable iff (rst)
    (!rep_valid && cmd_start && code_recoverable(code_q)) |=> code_q == '0); // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rep_valid && !(cmd_start && code_recoverable(code_q))) |=> $stable(code_q)); // R3
endmodule

// File: rtl/intr_sticky_bank.sv
module intr_sticky_bank
  import err_irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] hw_set,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_mask,
  input  logic               en_we,
  input  logic [NUM_IRQ-1:0] en_wdata,
  input  logic               test_we,
  input  logic [NUM_IRQ-1:0] test_mask,
  output logic [NUM_IRQ-1:0] state_q,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] irq_q
);
  logic [NUM_IRQ-1:0] clr_eff, force_eff, state_d;

  assign clr_eff   = clr_we  ? clr_mask  : '0;
  assign force_eff = test_we ? test_mask : '0;
  assign state_d   = (state_q & ~clr_eff) | hw_set | force_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      en_q    <= '0;
      irq_q   <= '0;
    end else begin
      state_q <= state_d;
      if (en_we) en_q <= en_wdata;
      irq_q <= state_q & en_q;
    end
  end

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      hw_set[b] |=> state_q[b]); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[b] && !hw_set[b] && !(test_we && test_mask[b])) |=> !state_q[b]); // R6
    AST_FORCE: assert property (@(posedge clk) disable iff (rst)
      (test_we && test_mask[b]) |=> state_q[b]); // R9
    AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
      (state_q[b] && en_q[b]) |=> irq_q[b]); // R8
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
      !(state_q[b] && en_q[b]) |=> !irq_q[b]); // R8
  end
endmodule

// File: rtl/alert_event_gen.sv
module alert_event_gen
  import err_irq_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  macro_any,
  input  logic                  check_any,
  input  logic                  test_we,
  input  logic [NUM_ALERTS-1:0] test_mask,
  output logic [NUM_ALERTS-1:0] alert_q
);
  logic [NUM_ALERTS-1:0] alert_d;

  always_comb begin
    alert_d = test_we ? test_mask : '0;
    alert_d[ALT_MACRO] = alert_d[ALT_MACRO] | macro_any;
    alert_d[ALT_CHECK] = alert_d[ALT_CHECK] | check_any;
  end

  always_ff @(posedge clk) begin
    if (rst) alert_q <= '0;
    else     alert_q <= alert_d;
  end

  AST_MACRO_FIRES: assert property (@(posedge clk) disable iff (rst)
    macro_any |=> alert_q[ALT_MACRO]); // R5
  AST_CHECK_FIRES: assert property (@(posedge clk) disable iff (rst)
    check_any |=> alert_q[ALT_CHECK]); // R5
  AST_MACRO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!macro_any && !(test_we && test_mask[ALT_MACRO])) |=> !alert_q[ALT_MACRO]); // R5

  for (genvar b = 0; b < NUM_ALERTS; b++) begin : g_tst
    AST_TEST_FIRES: assert property (@(posedge clk) disable iff (rst)
      (test_we && test_mask[b]) |=> alert_q[b]); // R10
  end
endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg
  import err_irq_agg_pkg::*;
#(
  parameter int NUM_AGENTS = 13,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CODE_BASE  = 'h40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_AGENTS-1:0]        agent_err_valid,
  input  logic [NUM_AGENTS*CODE_W-1:0] agent_err_code,
  input  logic [NUM_AGENTS-1:0]        agent_cmd_start,
  input  logic                         op_done,
  input  logic                         reg_valid,
  input  logic                         reg_write,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         irq_error,
  output logic                         irq_op_done,
  output logic                         alert_macro,
  output logic                         alert_check,
  output logic                         alert_bus_integ,
  output logic                         alert_prim_fatal,
  output logic                         alert_prim_recov
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_TEST   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_ALERT  = ADDR_W'('h10);

  logic [CODE_W-1:0]     code_q [NUM_AGENTS];
  logic [NUM_AGENTS-1:0] err_hit, macro_hit, check_hit, status_vec;

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    agent_code_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .rep_valid (agent_err_valid[i]),
      .rep_code  (agent_err_code[i*CODE_W +: CODE_W]),
      .cmd_start (agent_cmd_start[i]),
      .code_q    (code_q[i]),
      .err_hit   (err_hit[i]),
      .macro_hit (macro_hit[i]),
      .check_hit (check_hit[i])
    );
    assign status_vec[i] = |code_q[i];
  end

  logic wr_en, rd_en;
  assign wr_en = reg_valid && reg_write;
  assign rd_en = reg_valid && !reg_write;

  logic [NUM_IRQ-1:0] state_q, en_q, irq_q, hw_set;
  assign hw_set[IRQ_ERR_BIT]  = |err_hit;
  assign hw_set[IRQ_DONE_BIT] = op_done;

  intr_sticky_bank u_intr (
    .clk       (clk),
    .rst       (rst),
    .hw_set    (hw_set),
    .clr_we    (wr_en && reg_addr == A_STATE),
    .clr_mask  (reg_wdata[NUM_IRQ-1:0]),
    .en_we     (wr_en && reg_addr == A_ENABLE),
    .en_wdata  (reg_wdata[NUM_IRQ-1:0]),
    .test_we   (wr_en && reg_addr == A_TEST),
    .test_mask (reg_wdata[NUM_IRQ-1:0]),
    .state_q   (state_q),
    .en_q      (en_q),
    .irq_q     (irq_q)
  );
  assign irq_error   = irq_q[IRQ_ERR_BIT];
  assign irq_op_done = irq_q[IRQ_DONE_BIT];

  logic [NUM_ALERTS-1:0] alert_q;
  alert_event_gen u_alert (
    .clk       (clk),
    .rst       (rst),
    .macro_any (|macro_hit),
    .check_any (|check_hit),
    .test_we   (wr_en && reg_addr == A_ALERT),
    .test_mask (reg_wdata[NUM_ALERTS-1:0]),
    .alert_q   (alert_q)
  );
  assign alert_macro      = alert_q[ALT_MACRO];
  assign alert_check      = alert_q[ALT_CHECK];
  assign alert_bus_integ  = alert_q[ALT_BUS];
  assign alert_prim_fatal = alert_q[ALT_PRIM_FATAL];
  assign alert_prim_recov = alert_q[ALT_PRIM_RECOV];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_STATUS) rd_mux[NUM_AGENTS-1:0] = status_vec;
    if (reg_addr == A_STATE)  rd_mux[NUM_IRQ-1:0]    = state_q;
    if (reg_addr == A_ENABLE) rd_mux[NUM_IRQ-1:0]    = en_q;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (reg_addr == ADDR_W'(CODE_BASE + 4*i)) rd_mux[CODE_W-1:0] = code_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_mux;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|err_hit) |=> state_q[IRQ_ERR_BIT]); // R4
  AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == A_STATUS) |=> reg_rdata[NUM_AGENTS-1:0] == $past(status_vec)); // R2
endmodule

// File: tb/sim_err_irq_agg.sv
`timescale 1ns/1ps
module sim_err_irq_agg;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  agent_err_valid = '0;
  logic [N*3-1:0] agent_err_code = '0;
  logic [N-1:0]  agent_cmd_start = '0;
  logic          op_done = 1'b0;
  logic          reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_error, irq_op_done;
  logic          alert_macro, alert_check, alert_bus_integ, alert_prim_fatal, alert_prim_recov;

  int checks = 0;
  int failures = 0;
  logic [4:0] snap;

  always #2.5 clk = ~clk;

  err_irq_agg u0 (
    .clk(clk), .rst(rst),
    .agent_err_valid(agent_err_valid), .agent_err_code(agent_err_code),
    .agent_cmd_start(agent_cmd_start), .op_done(op_done),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_error(irq_error), .irq_op_done(irq_op_done),
    .alert_macro(alert_macro), .alert_check(alert_check),
    .alert_bus_integ(alert_bus_integ), .alert_prim_fatal(alert_prim_fatal),
    .alert_prim_recov(alert_prim_recov)
  );

  function automatic logic [4:0] alerts();
    return {alert_prim_recov, alert_prim_fatal, alert_bus_integ, alert_check, alert_macro};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    snap = alerts();
    reg_valid = 0; reg_write = 0;
    agent_err_valid = '0; agent_cmd_start = '0; op_done = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    finish_cycle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    finish_cycle();
    d = reg_rdata;
  endtask

  task automatic report(input int idx, input logic [2:0] c);
    @(negedge clk);
    agent_err_valid[idx] = 1'b1;
    agent_err_code[idx*3 +: 3] = c;
    finish_cycle();
  endtask

  task automatic cmd(input int idx);
    @(negedge clk);
    agent_cmd_start[idx] = 1'b1;
    finish_cycle();
  endtask

  function automatic logic [7:0] code_addr(input int idx);
    return 8'(8'h40 + 4*idx);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R11 status", d, 0);
    rd(8'h04, d); chk("R11 state", d, 0);
    rd(8'h08, d); chk("R11 enable", d, 0);
    for (int i = 0; i < N; i++) begin
      rd(code_addr(i), d); chk("R11 code", d, 0);
    end
    chk("R11 irq", {30'd0, irq_error, irq_op_done}, 0);
    chk("R11 alerts", 32'(alerts()), 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    report(3, 3'd2);
    chk("R5 code2 no alert", 32'(snap), 0);
    rd(code_addr(3), d); chk("R1 code agent3", d, 2);
    rd(8'h00, d); chk("R2 status bit3", d, 32'h8);
    rd(8'h04, d); chk("R4 err state set", d, 32'h2);
    report(12, 3'd7);
    chk("R5 code7 check alert", 32'(snap), 32'h2);
    @(negedge clk);
    chk("R5 alert single cycle", 32'(alerts()), 0);
    rd(code_addr(12), d); chk("R1 code agent12", d, 7);
    rd(8'h00, d); chk("R2 status bits 3,12", d, 32'h1008);
    report(1, 3'd3);
    chk("R5 code3 macro alert", 32'(snap), 32'h1);
    report(9, 3'd1);
    chk("R5 code1 macro alert", 32'(snap), 32'h1);
    report(10, 3'd6);
    chk("R5 code6 check alert", 32'(snap), 32'h2);
  endtask

  task automatic t_recover();
    logic [31:0] d;
    cmd(3);
    rd(code_addr(3), d); chk("R3 code2 cleared", d, 0);
    cmd(12);
    rd(code_addr(12), d); chk("R3 code7 kept", d, 7);
    cmd(1);
    rd(code_addr(1), d); chk("R3 code3 kept", d, 3);
    @(negedge clk);
    agent_err_valid[5] = 1; agent_err_code[15 +: 3] = 3'd4; agent_cmd_start[5] = 1;
    finish_cycle();
    rd(code_addr(5), d); chk("R3 report beats start", d, 4);
    cmd(5);
    rd(code_addr(5), d); chk("R3 code4 cleared", d, 0);
    report(0, 3'd5);
    cmd(0);
    rd(code_addr(0), d); chk("R3 code5 cleared", d, 0);
    rd(8'h00, d); chk("R2 status after clears", d, 32'h1602);
  endtask

  task automatic t_state();
    logic [31:0] d;
    wr(8'h04, 32'h2);
    rd(8'h04, d); chk("R6 w1c err", d, 0);
    report(7, 3'd0);
    rd(8'h04, d); chk("R4 code0 no set", d, 0);
    @(negedge clk); op_done = 1; finish_cycle();
    rd(8'h04, d); chk("R6 op_done sets bit0", d, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, d); chk("R6 w1c done", d, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    report(2, 3'd1);
    @(negedge clk);
    agent_err_valid[2] = 1; agent_err_code[6 +: 3] = 3'd1; op_done = 1;
    reg_valid = 1; reg_write = 1; reg_addr = 8'h04; reg_wdata = 32'h3;
    finish_cycle();
    rd(8'h04, d); chk("R7 set beats clear", d, 32'h3);
    wr(8'h04, 32'h3);
    rd(8'h04, d); chk("R6 both cleared", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    report(4, 3'd5);
    wr(8'h08, 32'h3);
    rd(8'h08, d); chk("R8 enable readback", d, 32'h3);
    chk("R8 irq lines", {30'd0, irq_error, irq_op_done}, 32'h2);
    wr(8'h08, 32'h1);
    @(negedge clk);
    chk("R8 err masked", {30'd0, irq_error, irq_op_done}, 0);
    wr(8'h0C, 32'h1);
    rd(8'h0C, d); chk("R9 test reads zero", d, 0);
    chk("R9 forced done irq", {30'd0, irq_error, irq_op_done}, 32'h1);
    rd(8'h04, d); chk("R9 forced state", d, 32'h3);
    wr(8'h04, 32'h3);
    @(negedge clk);
    chk("R8 irq drops after clear", {30'd0, irq_error, irq_op_done}, 0);
  endtask

  task automatic t_alert_test();
    for (int b = 0; b < 5; b++) begin
      wr(8'h10, 32'(1 << b));
      chk("R10 alert test bit", 32'(snap), 32'(1 << b));
      @(negedge clk);
      chk("R10 alert one pulse", 32'(alerts()), 0);
    end
    wr(8'h10, 32'h1F);
    chk("R10 all alerts", 32'(snap), 32'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_capture();
    t_recover();
    t_state();
    t_priority();
    t_enable();
    t_alert_test();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule